// File: doc/BRIEF.md
# Time-Redundant Segmented Checking Adder

This block adds two 16-bit operands and a carry-in on a 4-bit adder slice. It works through the operands one nibble per clock cycle, starting with the least significant nibble. A single carry register holds the carry from one nibble cycle and feeds it into the next. Each nibble is added by three identical slice replicas at the same time. A judging stage then either takes the bitwise majority of the three results, or compares two of them, depending on the mode chosen when the operation starts. Majority voting hides a single faulty replica and raises a corrected flag. Comparison raises an error flag.

A client pulses `start` while the block is idle, with the operands, carry-in and mode on the inputs. Some cycles later, `done` pulses for one cycle. At that point the sum, the carry-out and both flags are valid, and they stay unchanged until the next operation ends. A fault-injection hook can force any one replica's 5-bit nibble result to a fixed value. This lets the detection and correction paths be exercised on demand.

Top module: `seg_tmr_adder`

## Requirements
- R1: When `start` is high on a rising edge while the block is idle, the block captures `a`, `b`, `cin` and `vote_mode`. It then handles one nibble per cycle, from bits 3:0 up to bits 15:12. `done` is high during the cycle that follows the fourth rising edge after the capturing edge.
- R2: With no fault injected, `sum` equals (a + b + cin) modulo 2^16 and `cout` equals bit 16 of that total. This holds in both modes, with `err` and `corrected` both low.
- R3: Nibble 0 takes `cin` as its carry-in. Each later nibble takes, as its carry-in, the carry produced by the judging stage for the nibble before it, held in the carry register. `cout` is the judged carry of the top nibble.
- R4: In vote mode (`vote_mode`=1), each nibble's 5-bit result {carry, sum} is the bitwise majority of replicas 0, 1 and 2. If any one replica is stuck, the sum and carry-out are still correct. `corrected` is 1 exactly when the replicas disagreed on at least one nibble.
- R5: In vote mode `err` stays 0. `corrected` is 0 when all three replicas agree on every nibble.
- R6: In compare mode (`vote_mode`=0), the result and carry come from replica 0. `err` is 1 exactly when replicas 0 and 1 differed in the sum or the carry of at least one nibble. `corrected` stays 0.
- R7: In compare mode replica 2 is unused, so forcing it changes neither the result nor either flag.
- R8: `done` is high for exactly one cycle per accepted operation. `sum`, `cout`, `err` and `corrected` hold their values until the next operation completes.
- R9: `start` is ignored while an operation is in progress. It causes neither a restart, nor a change to the result, nor an extra `done`.
- R10: After reset, `done`, `sum`, `cout`, `err` and `corrected` are all 0.
- R11: While `inj_en` is high, the 5-bit output of the replica numbered `inj_sel` (0 to 2) is replaced on every nibble cycle by `inj_val`, with bit 4 as the carry and bits 3:0 as the sum. `inj_sel`=3 selects no replica, so it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request an addition; accepted only when idle |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into the lowest nibble |
| vote_mode | input | 1 | 1 = three-way majority, 0 = two-way compare |
| inj_en | input | 1 | Enable the stuck-value override |
| inj_sel | input | 2 | Replica forced by the override |
| inj_val | input | 5 | Forced {carry, sum} value |
| done | output | 1 | One-cycle completion strobe |
| sum | output | 16 | Registered result |
| cout | output | 1 | Registered carry-out |
| err | output | 1 | Compare-mode mismatch seen |
| corrected | output | 1 | Vote-mode disagreement masked |

## Verification
Directed operand pairs exercise the carry path:
- 0x0FFF + 1 and 0xFFFF + 0 + 1 send a carry across every nibble boundary, which shows whether the carry register is used at all.
- 0xFFFF + 0xFFFF + 1 sets every carry at once.

Each replica in turn is forced in both modes. In vote mode this shows that the output stays correct while `corrected` rises. In compare mode it shows that replicas 0 and 1 raise `err`, that a fault on replica 0 shows up in the sum, and that replica 2 has no effect. A `start` pulse with different operands during a run shows whether busy-time requests are ignored. A long run with random operands, modes and injected faults checks results and flags against a nibble-level model. In that model, a stuck value that happens to equal the true nibble result must not raise a flag.

// File: rtl/seg_add_pkg.sv
package seg_add_pkg;
  localparam int REPLICAS = 3;

  typedef enum logic {
    MODE_CMP  = 1'b0,
    MODE_VOTE = 1'b1
  } chk_mode_e;
endpackage

// File: rtl/seg_replica.sv
module seg_replica #(
  parameter int SEG_W = 4,
  parameter int SEL_W = 2,
  parameter int IDX   = 0
) (
  input  logic [SEG_W-1:0] sa,
  input  logic [SEG_W-1:0] sb,
  input  logic             ci,
  input  logic             inj_en,
  input  logic [SEL_W-1:0] inj_sel,
  input  logic [SEG_W:0]   inj_val,
  output logic [SEG_W:0]   res
);
  localparam logic [SEL_W-1:0] MY_ID = SEL_W'(IDX);

  logic [SEG_W:0] raw;

  // slice adder: {carry, sum}
  assign raw = {1'b0, sa} + {1'b0, sb} + {{SEG_W{1'b0}}, ci};

  // stuck-value override for this replica only
  assign res = (inj_en && (inj_sel == MY_ID)) ? inj_val : raw;
endmodule

// File: rtl/seg_judge.sv
module seg_judge #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] r0,
  input  logic [RW-1:0] r1,
  input  logic [RW-1:0] r2,
  input  logic          vote,
  output logic [RW-1:0] res,
  output logic          cmp_diff,
  output logic          vote_diff
);
  logic [RW-1:0] maj;

  assign maj       = (r0 & r1) | (r1 & r2) | (r0 & r2);
  assign res       = vote ? maj : r0;
  assign cmp_diff  = (r0 != r1);
  assign vote_diff = (r0 != r1) || (r1 != r2);
endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer #(
  parameter int NSEG  = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             accept,
  output logic             last,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NSEG - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  assign busy   = busy_q;
  assign idx    = idx_q;
  assign accept = start && !busy_q;
  assign last   = busy_q && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  // R1: segments advance by one per cycle until the last
  a_r1_seg_step: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !last) |=> (busy_q && (idx_q == $past(idx_q) + 1'b1)));

  // R9: a start during a run never restarts the sequence
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start) |=> !(busy_q && (idx_q == '0)));
endmodule

// File: rtl/seg_tmr_adder.sv
module seg_tmr_adder #(
  parameter int WIDTH = 16,
  parameter int SEG_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic             vote_mode,
  input  logic             inj_en,
  input  logic [SEL_W-1:0] inj_sel,
  input  logic [SEG_W:0]   inj_val,
  output logic             done,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             err,
  output logic             corrected
);
  import seg_add_pkg::*;

  localparam int NSEG  = WIDTH / SEG_W;
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1;
  localparam int RW    = SEG_W + 1;

  logic             busy, accept, last;
  logic [IDX_W-1:0] idx;

  logic [WIDTH-1:0] a_q, b_q, part_q, part_next;
  logic             carry_q, err_acc, corr_acc;
  chk_mode_e        mode_q;
  logic             is_vote;

  logic [SEG_W-1:0] seg_a, seg_b;
  logic [RW-1:0]    rep [REPLICAS];
  logic [RW-1:0]    seg_res;
  logic             cmp_diff, vote_diff;
  logic             err_now, corr_now;

  seg_sequencer #(.NSEG(NSEG), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .busy(busy), .accept(accept), .last(last), .idx(idx)
  );

  assign is_vote = (mode_q == MODE_VOTE);
  assign seg_a   = a_q[int'(idx)*SEG_W +: SEG_W];
  assign seg_b   = b_q[int'(idx)*SEG_W +: SEG_W];

  generate
    for (genvar r = 0; r < REPLICAS; r++) begin : g_rep
      seg_replica #(.SEG_W(SEG_W), .SEL_W(SEL_W), .IDX(r)) u_rep (
        .sa(seg_a), .sb(seg_b), .ci(carry_q),
        .inj_en(inj_en), .inj_sel(inj_sel), .inj_val(inj_val),
        .res(rep[r])
      );
    end
  endgenerate

  seg_judge #(.RW(RW)) u_judge (
    .r0(rep[0]), .r1(rep[1]), .r2(rep[2]), .vote(is_vote),
    .res(seg_res), .cmp_diff(cmp_diff), .vote_diff(vote_diff)
  );

  assign err_now  = !is_vote && cmp_diff;
  assign corr_now = is_vote && vote_diff;

  always_comb begin
    part_next = part_q;
    part_next[int'(idx)*SEG_W +: SEG_W] = seg_res[SEG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q       <= '0;
      b_q       <= '0;
      part_q    <= '0;
      carry_q   <= 1'b0;
      mode_q    <= MODE_CMP;
      err_acc   <= 1'b0;
      corr_acc  <= 1'b0;
      done      <= 1'b0;
      sum       <= '0;
      cout      <= 1'b0;
      err       <= 1'b0;
      corrected <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        a_q      <= a;
        b_q      <= b;
        carry_q  <= cin;
        mode_q   <= chk_mode_e'(vote_mode);
        part_q   <= '0;
        err_acc  <= 1'b0;
        corr_acc <= 1'b0;
      end else if (busy) begin
        part_q   <= part_next;
        carry_q  <= seg_res[SEG_W];
        err_acc  <= err_acc | err_now;
        corr_acc <= corr_acc | corr_now;
        if (last) begin
          done      <= 1'b1;
          sum       <= part_next;
          cout      <= seg_res[SEG_W];
          err       <= err_acc | err_now;
          corrected <= corr_acc | corr_now;
        end
      end
    end
  end

  // R4: when two replicas agree in vote mode, their value wins
  a_r4_majority: assert property (@(posedge clk) disable iff (rst)
    (busy && is_vote && (rep[0] == rep[1])) |-> (seg_res == rep[0]));

  // R6: a compare-mode mismatch is remembered
  a_r6_cmp_flag: assert property (@(posedge clk) disable iff (rst)
    (busy && !is_vote && (rep[0] != rep[1])) |=> err_acc);

  // R5: vote mode never reports an error
  a_r5_vote_no_err: assert property (@(posedge clk) disable iff (rst)
    (done && is_vote) |-> !err);

  // R8: done is a single-cycle strobe
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R1: done only follows the final segment
  a_r1_done_after_last: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(last));
endmodule

// File: tb/seg_tmr_adder_test.sv
`timescale 1ns/1ps
module seg_tmr_adder_test;
  localparam int W  = 16;
  localparam int S  = 4;
  localparam int NS = W / S;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          cin = 1'b0;
  logic          vote = 1'b0;
  logic          inj_en = 1'b0;
  logic [1:0]    inj_sel = '0;
  logic [S:0]    inj_val = '0;
  logic          done, cout, err, corr;
  logic [W-1:0]  sum;

  int  checks = 0;
  int  fails  = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  seg_tmr_adder uut (
    .clk(clk), .rst(rst), .start(start), .a(a), .b(b), .cin(cin),
    .vote_mode(vote), .inj_en(inj_en), .inj_sel(inj_sel), .inj_val(inj_val),
    .done(done), .sum(sum), .cout(cout), .err(err), .corrected(corr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // returns {err, corrected, cout, sum}
  function automatic logic [W+2:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
      input logic ci, input logic md, input logic ie, input logic [1:0] sel,
      input logic [S:0] iv);
    logic c, e, k;
    logic [W-1:0] s;
    c = ci; e = 1'b0; k = 1'b0; s = '0;
    for (int g = 0; g < NS; g++) begin
      logic [S:0] t, r0, r1, r2, res;
      t  = {1'b0, x[g*S +: S]} + {1'b0, y[g*S +: S]} + {{S{1'b0}}, c};
      r0 = (ie && sel == 2'd0) ? iv : t;
      r1 = (ie && sel == 2'd1) ? iv : t;
      r2 = (ie && sel == 2'd2) ? iv : t;
      if (md) begin
        res = (r0 & r1) | (r1 & r2) | (r0 & r2);
        if (r0 != r1 || r1 != r2) k = 1'b1;
      end else begin
        res = r0;
        if (r0 != r1) e = 1'b1;
      end
      s[g*S +: S] = res[S-1:0];
      c = res[S];
    end
    return {e, k, c, s};
  endfunction

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input logic ci,
      input logic md, input logic ie, input logic [1:0] sel, input logic [S:0] iv,
      input bit poke, input string req);
    int n;
    logic [W+2:0] exp;
    exp = model(x, y, ci, md, ie, sel, iv);
    @(negedge clk);
    a = x; b = y; cin = ci; vote = md;
    inj_en = ie; inj_sel = sel; inj_val = iv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 12) begin
      @(negedge clk);
      n++;
      if (poke && n == 1) begin
        start = 1'b1; a = ~x; b = 16'h1234; cin = ~ci; vote = ~md;
      end else begin
        start = 1'b0;
      end
    end
    check(n == NS, "R1", "done latency", n, NS);
    check(sum == exp[W-1:0], req, "sum", sum, exp[W-1:0]);
    check(cout == exp[W], req, "cout", cout, exp[W]);
    check({err, corr} == exp[W+2:W+1], req, "err/corrected", {err, corr}, exp[W+2:W+1]);
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", done, 0);
    if (poke) begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check(!done && sum == exp[W-1:0], "R9", "no extra done, result held",
              {done, sum}, {1'b0, exp[W-1:0]});
      end
    end
    inj_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check({done, sum, cout, err, corr} == '0, "R10", "reset state",
          {done, sum, cout, err, corr}, 0);
    rst = 1'b0;

    run_op(16'h0FFF, 16'h0001, 1'b0, 1'b1, 1'b0, 2'd0, 5'h00, 0, "R3");
    run_op(16'hFFFF, 16'h0000, 1'b1, 1'b0, 1'b0, 2'd0, 5'h00, 0, "R3");
    run_op(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 2'd0, 5'h00, 0, "R2");
    run_op(16'h1357, 16'h2468, 1'b0, 1'b1, 1'b0, 2'd0, 5'h00, 0, "R5");
    run_op(16'hA5A5, 16'h5A5A, 1'b1, 1'b1, 1'b1, 2'd0, 5'h1F, 0, "R4");
    run_op(16'hFFFF, 16'h0000, 1'b1, 1'b1, 1'b1, 2'd1, 5'h00, 0, "R4");
    run_op(16'h8421, 16'h7BDE, 1'b0, 1'b1, 1'b1, 2'd2, 5'h10, 0, "R4");
    run_op(16'h1234, 16'h4321, 1'b0, 1'b1, 1'b1, 2'd3, 5'h1F, 0, "R11");
    run_op(16'h1234, 16'h4321, 1'b0, 1'b0, 1'b1, 2'd2, 5'h1F, 0, "R7");
    run_op(16'h1234, 16'h4321, 1'b0, 1'b0, 1'b1, 2'd0, 5'h00, 0, "R6");
    run_op(16'h00FF, 16'h0F01, 1'b1, 1'b0, 1'b1, 2'd1, 5'h15, 0, "R6");
    run_op(16'hBEEF, 16'h1111, 1'b0, 1'b1, 1'b0, 2'd0, 5'h00, 1, "R9");

    for (int i = 0; i < 400; i++) begin
      logic md, ie;
      md = 1'($urandom);
      ie = ($urandom % 4) == 0;
      run_op(16'($urandom), 16'($urandom), 1'($urandom), md, ie,
             2'($urandom), 5'($urandom), 0, !ie ? "R2" : (md ? "R4" : "R6"));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule